// File: doc/BRIEF.md
# Multi-Channel Fan Tachometer Monitor

This block watches the tachometer pulses of up to twelve fans and reports, for each one, how long its last full revolution pulse period lasted. The period is expressed as the number of reference ticks seen between two consecutive rising tach edges. The tick is a single-cycle enable supplied by the surrounding chip. The result is a 13-bit count. A fan that stops produces no edges, so its counter climbs to the all-ones value and stays there. That value marks a stalled or absent fan. A count of zero means that no complete period has been measured yet.

Every channel has a programmable 13-bit low-speed limit. A long period means a slow fan. When a finished period, or a counter that has just saturated, exceeds the limit, the channel raises a sticky alarm bit. The alarm bits are packed eight channels to a status byte. Reading a status byte returns the latched bits and clears them.

Software reaches the block through a simple byte-wide register port. A count or limit is split across two registers: the upper eight bits in one and the lower five bits in the other. Reading the upper byte of a count freezes the matching lower byte, so the two halves always come from the same measurement.

Top module: `fan_tach_monitor`

## Requirements
- R1: A channel's count equals the number of cycles with `tick` high in the interval after one qualified rising tach edge, up to and including the next. The first edge after a channel is enabled only starts timing, so the count stays 0 until a second edge arrives.
- R2: Channel k's count is read in two parts. Address 0x00+2k returns count bits 12:5. Address 0x01+2k returns count bits 4:0 in data bits 4:0, with bits 7:5 reading 0.
- R3: Reading address 0x00+2k captures that channel's low five count bits. The next read of 0x01+2k returns the captured bits, even if a newer measurement has completed in between.
- R4: With no tach edge, the counter stops at 0x1FFF after 8191 ticks, loads 0x1FFF into the count, and holds that value without wrapping until an edge arrives.
- R5: Channel k is enabled by bit k of a 16-bit mask. Address 0x48 holds mask bits 7:0 and address 0x49 holds bits 15:8; the mask resets to 0. A disabled channel reads a count of 0 and never sets an alarm.
- R6: Channel k's limit is written and read at 0x20+2k (limit bits 12:5) and 0x21+2k (limit bits 4:0 in data bits 4:0). The limit resets to 0x1FFF.
- R7: An alarm sets when a completed count, or a count that has just saturated, is strictly greater than the channel's limit. A count equal to the limit sets no alarm.
- R8: Channel k's alarm is bit k mod 8 of status byte k div 8. Status byte 0 is at address 0x40 and status byte 1 is at 0x41.
- R9: An alarm bit stays set until its status byte is read, even if the condition goes away. A read returns the latched byte and clears it, but an alarm that sets in the same cycle as the read survives.
- R10: `reg_rdata` is loaded on the clock edge where `reg_rd` is sampled high and holds its value until the next read. Unmapped addresses read 0.
- R11: The period counter advances only on cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference tick enable for the period counters |
| tach | input | NCH (12) | Raw tach inputs, one per fan, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, registered |

## Verification
Some rules are checked by assertions on every cycle for every channel:
- a disabled channel's count is zero and its alarm bit cannot rise;
- a saturated counter stays saturated until an edge arrives;
- an alarm bit stays latched unless its status byte is read;
- a read clears every bit that is not being set in the same cycle.

Other behaviour can only be shown by the bench's scenarios, because the expected values depend on the stimulus:
- the exact period values, under full-rate and half-rate ticks;
- the first-edge arming rule;
- the frozen low byte across a new measurement;
- the strict greater-than comparison at the limit;
- the packing of a channel above seven into the second status byte.

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
  parameter int NCH    = 12,
  parameter int CNT_W  = 13,
  parameter int MASK_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [NCH-1:0] tach,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [7:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata
);
  localparam int HI_W = 8;
  localparam int LO_W = CNT_W - HI_W;
  localparam int NSTAT = (NCH + 7) / 8;
  localparam int CNT_BASE  = 8'h00;
  localparam int LIM_BASE  = 8'h20;
  localparam int STAT_BASE = 8'h40;
  localparam int EN_BASE   = 8'h48;
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [NCH-1:0] s1, s2, s3;
  logic [NCH-1:0] edge_det, en, alarm_set;
  logic [MASK_W-1:0] en_mask;
  logic [NCH*CNT_W-1:0] cnt_v, run_v, lim_v;
  logic [NCH*LO_W-1:0] snap_v;
  logic [NSTAT*8-1:0] stat, set_w;
  logic [7:0] rd_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s3, s2, s1} <= '0;
    else        {s3, s2, s1} <= {s2, s1, tach};

  assign edge_det = s2 & ~s3;
  assign en       = en_mask[NCH-1:0];
  assign set_w    = (NSTAT*8)'(alarm_set);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam logic [7:0] A_CHI = 8'(CNT_BASE + 2*k);
    localparam logic [7:0] A_LHI = 8'(LIM_BASE + 2*k);
    logic [CNT_W-1:0] run_q, cnt_q, lim_q, nxt, ev_val;
    logic [LO_W-1:0]  snap_q;
    logic armed, sat_hit, capture, ev;

    assign nxt     = (run_q == SAT) ? SAT : run_q + CNT_W'(tick);
    assign sat_hit = tick && (run_q == SAT - 1'b1);
    assign capture = edge_det[k] && armed;
    assign ev      = capture || sat_hit;
    assign ev_val  = capture ? nxt : SAT;
    assign alarm_set[k] = en[k] && ev && (ev_val > lim_q);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run_q <= '0;
        cnt_q <= '0;
        armed <= 1'b0;
      end else if (!en[k]) begin
        run_q <= '0;
        cnt_q <= '0;
        armed <= 1'b0;
      end else begin
        if (edge_det[k]) begin
          run_q <= '0;
          armed <= 1'b1;
        end else begin
          run_q <= nxt;
        end
        if (ev) cnt_q <= ev_val;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lim_q  <= SAT;
        snap_q <= '0;
      end else begin
        if (reg_wr && reg_addr == A_LHI)        lim_q[CNT_W-1:LO_W] <= reg_wdata;
        if (reg_wr && reg_addr == A_LHI + 8'd1) lim_q[LO_W-1:0]     <= reg_wdata[LO_W-1:0];
        if (reg_rd && reg_addr == A_CHI)        snap_q              <= cnt_q[LO_W-1:0];
      end

    assign cnt_v[k*CNT_W +: CNT_W] = cnt_q;
    assign run_v[k*CNT_W +: CNT_W] = run_q;
    assign lim_v[k*CNT_W +: CNT_W] = lim_q;
    assign snap_v[k*LO_W +: LO_W]  = snap_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat    <= '0;
      en_mask <= '0;
    end else begin
      for (int b = 0; b < NSTAT; b++)
        stat[b*8 +: 8] <= ((reg_rd && reg_addr == 8'(STAT_BASE + b)) ? 8'h00 : stat[b*8 +: 8])
                          | set_w[b*8 +: 8];
      for (int b = 0; b < MASK_W/8; b++)
        if (reg_wr && reg_addr == 8'(EN_BASE + b)) en_mask[b*8 +: 8] <= reg_wdata;
    end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NCH; k++) begin
      if (reg_addr == 8'(CNT_BASE + 2*k))     rd_val = cnt_v[k*CNT_W + LO_W +: HI_W];
      if (reg_addr == 8'(CNT_BASE + 2*k + 1)) rd_val = 8'(snap_v[k*LO_W +: LO_W]);
      if (reg_addr == 8'(LIM_BASE + 2*k))     rd_val = lim_v[k*CNT_W + LO_W +: HI_W];
      if (reg_addr == 8'(LIM_BASE + 2*k + 1)) rd_val = 8'(lim_v[k*CNT_W +: LO_W]);
    end
    for (int b = 0; b < NSTAT; b++)
      if (reg_addr == 8'(STAT_BASE + b)) rd_val = stat[b*8 +: 8];
    for (int b = 0; b < MASK_W/8; b++)
      if (reg_addr == 8'(EN_BASE + b)) rd_val = en_mask[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
endmodule

// File: rtl/fan_tach_monitor_chk.sv
module fan_tach_monitor_chk #(
  parameter int NCH       = 12,
  parameter int CNT_W     = 13,
  parameter int STAT_BASE = 8'h40
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_rd,
  input logic [7:0]           reg_addr,
  input logic [NCH-1:0]       en,
  input logic [NCH-1:0]       edge_det,
  input logic [NCH-1:0]       alarm_set,
  input logic [NCH*CNT_W-1:0] cnt_v,
  input logic [NCH*CNT_W-1:0] run_v,
  input logic [((NCH+7)/8)*8-1:0] stat
);
  localparam logic [CNT_W-1:0] SAT = '1;

  for (genvar k = 0; k < NCH; k++) begin : g_a
    localparam logic [7:0] A_ST = 8'(STAT_BASE + k/8);
    logic st_rd;
    assign st_rd = reg_rd && reg_addr == A_ST;

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !en[k] |=> cnt_v[k*CNT_W +: CNT_W] == '0); // R5
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[k] && !stat[k]) |=> !stat[k]); // R5
    AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (en[k] && run_v[k*CNT_W +: CNT_W] == SAT && !edge_det[k]) |=> run_v[k*CNT_W +: CNT_W] == SAT); // R4
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[k] && !st_rd) |=> stat[k]); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd && !alarm_set[k]) |=> !stat[k]); // R9
  end
endmodule

bind fan_tach_monitor fan_tach_monitor_chk #(.NCH(NCH), .CNT_W(CNT_W), .STAT_BASE(STAT_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr), .en(en),
  .edge_det(edge_det), .alarm_set(alarm_set), .cnt_v(cnt_v), .run_v(run_v), .stat(stat)
);

// File: tb/tb_fan_tach_monitor.sv
module tb_fan_tach_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic [11:0] tach = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0;
  logic [7:0]  reg_rdata;

  int per [12];
  int ph  [12];
  int tick_half = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  fan_tach_monitor dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tach(tach),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #10 clk = ~clk;

  initial begin
    for (int k = 0; k < 12; k++) begin per[k] = 0; ph[k] = 0; end
    forever begin
      @(negedge clk);
      tick = tick_half != 0 ? ~tick : 1'b1;
      for (int k = 0; k < 12; k++) begin
        if (per[k] == 0) tach[k] = 1'b0;
        else begin
          ph[k] = (ph[k] + 1 >= per[k]) ? 0 : ph[k] + 1;
          tach[k] = ph[k] < per[k] / 2;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic rdchk(input logic [7:0] a, input int exp, input string req);
    logic [7:0] d;
    rd(a, d);
    chk(req, int'(d), exp);
  endtask

  task automatic setper(input int k, input int p);
    per[k] = p; ph[k] = 0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rdchk(8'h00, 0, "R2 reset count hi");
    rdchk(8'h01, 0, "R2 reset count lo");
    rdchk(8'h17, 0, "R2 reset ch11 lo");
    rdchk(8'h20, 8'hFF, "R6 reset limit hi");
    rdchk(8'h21, 8'h1F, "R6 reset limit lo");
    rdchk(8'h40, 0, "R8 reset status0");
    rdchk(8'h41, 0, "R8 reset status1");
    rdchk(8'h48, 0, "R5 reset mask");
    rdchk(8'h7F, 0, "R10 unmapped");
  endtask

  task automatic t_measure;
    setper(0, 100); setper(5, 37); setper(1, 64);
    wr(8'h48, 8'h21);
    waitc(400);
    rdchk(8'h00, 3, "R1 R2 ch0 hi");
    rdchk(8'h01, 4, "R1 R2 ch0 lo");
    rdchk(8'h0A, 1, "R1 R2 ch5 hi");
    rdchk(8'h0B, 5, "R1 R2 ch5 lo");
    rdchk(8'h02, 0, "R5 disabled ch1 hi");
    rdchk(8'h03, 0, "R5 disabled ch1 lo");
    setper(3, 200);
    wr(8'h48, 8'h29);
    waitc(150);
    rdchk(8'h06, 0, "R1 first edge only arms hi");
    rdchk(8'h07, 0, "R1 first edge only arms lo");
    waitc(450);
    rdchk(8'h06, 6, "R1 ch3 hi");
    rdchk(8'h07, 8, "R1 ch3 lo");
  endtask

  task automatic t_tick;
    tick_half = 1; setper(5, 60);
    waitc(300);
    rdchk(8'h0A, 0, "R11 half tick hi");
    rdchk(8'h0B, 30, "R11 half tick lo");
    tick_half = 0; setper(5, 37);
    waitc(200);
  endtask

  task automatic t_atomic;
    rdchk(8'h00, 3, "R3 hi before change");
    setper(0, 70);
    waitc(300);
    rdchk(8'h01, 4, "R3 lo frozen");
    rdchk(8'h00, 2, "R3 new hi");
    rdchk(8'h01, 6, "R3 new lo");
  endtask

  task automatic t_limit;
    wr(8'h22, 8'hAB); wr(8'h23, 8'hFF);
    rdchk(8'h22, 8'hAB, "R6 limit hi readback");
    rdchk(8'h23, 8'h1F, "R6 limit lo readback");
    wr(8'h22, 8'h00); wr(8'h23, 8'h00);
  endtask

  task automatic t_alarm;
    logic [7:0] d;
    rd(8'h40, d);
    wr(8'h20, 8'h02); wr(8'h21, 8'h06);
    waitc(250);
    rdchk(8'h40, 0, "R7 equal no alarm, R5 disabled ch1 quiet");
    wr(8'h21, 8'h05);
    waitc(150);
    wr(8'h20, 8'hFF); wr(8'h21, 8'h1F);
    waitc(250);
    rdchk(8'h40, 8'h01, "R7 R9 sticky alarm");
    rdchk(8'h40, 8'h00, "R9 cleared by read");
    setper(10, 50);
    wr(8'h34, 8'h01); wr(8'h35, 8'h08);
    wr(8'h49, 8'h04);
    waitc(200);
    rdchk(8'h49, 8'h04, "R5 mask hi readback");
    wr(8'h34, 8'hFF);
    rdchk(8'h41, 8'h04, "R8 ch10 in status1");
    rdchk(8'h41, 8'h00, "R9 status1 cleared");
  endtask

  task automatic t_stall;
    wr(8'h24, 8'h80); wr(8'h25, 8'h00);
    setper(2, 0);
    wr(8'h48, 8'h2D);
    waitc(8300);
    rdchk(8'h04, 8'hFF, "R4 stall hi");
    rdchk(8'h05, 8'h1F, "R4 stall lo");
    rdchk(8'h40, 8'h04, "R7 saturated alarm");
    waitc(9000);
    rdchk(8'h04, 8'hFF, "R4 no wrap");
    rdchk(8'h40, 8'h00, "R4 one event per saturation");
    setper(2, 100);
    waitc(350);
    rdchk(8'h04, 3, "R1 restart hi");
    rdchk(8'h05, 4, "R1 restart lo");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_measure;
    t_tick;
    t_atomic;
    t_limit;
    t_alarm;
    t_stall;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule